// File: doc/BRIEF.md
# AGC Synchronization and Hold-Off Controller

This block decides when one automatic gain control stage, placed after a decimating integrator-comb filter, takes a fresh update sample. It emits three single-cycle strobes to the surrounding datapath: force an update sample out (decimation then restarts toward the next sample), clear the filter, and load new loop parameters. It also drives a static bypass select for the gain stage.

There are two ways to start a synchronization. The first is an external pin sync, brought into the clock domain by a two-flop synchronizer and detected on its rising edge. It arms a retriggerable 16-bit hold-off down-counter, and the strobes fire when that counter runs out. The second is a software sync-now command carried in a control write. It acts at once, bypasses the counter and cancels any count in progress. One control bit selects whether a synchronization also clears the filter and reloads the parameters. Another bit can latch out every pin sync after the first one.

The control write is 4 bits wide: bit 0 bypass, bit 1 ignore-repeat, bit 2 init-on-sync, bit 3 sync-now. Bits 0 to 2 are stored. Bit 3 is never stored and acts only on the write that carries it.

Top module: `agc_sync_ctrl`

## Requirements
- R1: When a pin sync rises with hold-off value H (H ≥ 1), update_o pulses for exactly one cycle, and it is first seen H+3 clock edges after the first edge that samples the pin high.
- R2: A new pin-sync rising edge while a count is running reloads the counter with H, so the single update follows the later edge by H+3 edges.
- R3: While the hold-off value is zero, a pin sync never produces any strobe and never starts a count.
- R4: A control write with bit 3 set produces update_o on the next edge, cancels any running hold-off count, and no further update follows from that count.
- R5: Sync-now needs no clearing: each separate write with bit 3 set produces its own update pulse.
- R6: When init-on-sync is in effect, clear_o and load_o pulse in the same cycle as update_o. A sync-now takes this setting from bit 2 of its own write; a hold-off expiry takes it from the stored bit 2.
- R7: When init-on-sync is not in effect, update_o pulses while clear_o and load_o stay low.
- R8: With ignore-repeat (bit 1) set, only the first accepted pin sync starts a count, and later pin syncs produce no update.
- R9: A control write that changes ignore-repeat from 1 to 0 rearms the stage, so after it is set again the next pin sync is accepted.
- R10: bypass_o follows stored control bit 0 from the edge after the write.
- R11: If a sync-now lands on the cycle in which the hold-off count would expire, exactly one update pulse is produced.
- R12: After reset, all strobes and bypass_o are low, and no pin sync is latched out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 4 | Control write data: bit0 bypass, bit1 ignore-repeat, bit2 init-on-sync, bit3 sync-now |
| holdoff_i | input | 16 | Programmed hold-off count |
| pin_sync_i | input | 1 | External sync, asynchronous |
| update_o | output | 1 | Force update sample and restart decimation |
| clear_o | output | 1 | Clear the integrator-comb filter |
| load_o | output | 1 | Load new loop parameters |
| bypass_o | output | 1 | Bypass the gain stage |

## Verification
Every cycle, the assertions check the following: the counter reloads and counts down step by step; it is cleared by a sync-now; it never loads a zero hold-off; it stays blocked while the latch is set; the latch is rearmed by a 1-to-0 write; and the clear and load strobes are tied to the update strobe. Other behaviours can only be shown by the bench's scenarios. These are the end-to-end latency across the synchronizer and counter for each hold-off value, the retrigger timing, the single strobe when a sync-now and an expiry collide, and the choice of init source between write data and stored bit.

// File: rtl/agc_sync_pkg.sv
package agc_sync_pkg;
  typedef struct packed {
    logic sync_now;
    logic init_on_sync;
    logic ign_repeat;
    logic bypass;
  } agc_ctrl_t;
  localparam int unsigned CTRL_W = $bits(agc_ctrl_t);
endpackage

// File: rtl/agc_pin_edge.sv
module agc_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_sync
    if (gi == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[gi] <= 1'b0;
        else         sync_q[gi] <= sync_q[gi-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  assert_rise_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/agc_holdoff.sv
module agc_holdoff #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cancel_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cancel_i)         cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - ONE;
  end

  // a reload on the last count wins over the expiry
  assign expire_o = (cnt_q == ONE) && !load_i && !cancel_i;

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !cancel_i) |=> (cnt_q == $past(load_val_i)));
  assert_nonzero_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
  assert_count_down_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cancel_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  assert_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (cnt_q == '0));
endmodule

// File: rtl/agc_sync_gate.sv
module agc_sync_gate
  import agc_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  agc_ctrl_t        ctrl_wdata_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             rise_i,
  output logic             sync_now_o,
  output logic             pin_ok_o,
  output logic             init_sel_o,
  output logic             bypass_o
);
  logic byp_q, ign_q, init_q, latch_q;
  logic rearm;

  assign sync_now_o = ctrl_wr_i & ctrl_wdata_i.sync_now;
  assign rearm      = ctrl_wr_i & ign_q & ~ctrl_wdata_i.ign_repeat;
  assign pin_ok_o   = rise_i && (holdoff_i != '0) && !(ign_q && latch_q) && !sync_now_o;
  assign init_sel_o = sync_now_o ? ctrl_wdata_i.init_on_sync : init_q;
  assign bypass_o   = byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      ign_q  <= 1'b0;
      init_q <= 1'b0;
    end else if (ctrl_wr_i) begin
      byp_q  <= ctrl_wdata_i.bypass;
      ign_q  <= ctrl_wdata_i.ign_repeat;
      init_q <= ctrl_wdata_i.init_on_sync;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 latch_q <= 1'b0;
    else if (rearm)              latch_q <= 1'b0;
    else if (pin_ok_o && ign_q)  latch_q <= 1'b1;
  end

  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_q && latch_q) |-> !pin_ok_o);
  assert_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm |=> !latch_q);
endmodule

// File: rtl/agc_sync_ctrl.sv
module agc_sync_ctrl
  import agc_sync_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic [3:0]       ctrl_wdata_i,
  input  logic [CNT_W-1:0] holdoff_i,
  input  logic             pin_sync_i,
  output logic             update_o,
  output logic             clear_o,
  output logic             load_o,
  output logic             bypass_o
);
  agc_ctrl_t wdata;
  logic rise, sync_now, pin_ok, init_sel, expire, fire;
  logic upd_q, clr_q, ld_q;

  assign wdata = agc_ctrl_t'(ctrl_wdata_i);

  agc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_sync_i), .rise_o(rise)
  );

  agc_sync_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_wdata_i(wdata),
    .holdoff_i   (holdoff_i),
    .rise_i      (rise),
    .sync_now_o  (sync_now),
    .pin_ok_o    (pin_ok),
    .init_sel_o  (init_sel),
    .bypass_o    (bypass_o)
  );

  agc_holdoff #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (pin_ok),
    .load_val_i(holdoff_i),
    .cancel_i  (sync_now),
    .expire_o  (expire)
  );

  assign fire = sync_now | expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      clr_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      upd_q <= fire;
      clr_q <= fire & init_sel;
      ld_q  <= fire & init_sel;
    end
  end

  assign update_o = upd_q;
  assign clear_o  = clr_q;
  assign load_o   = ld_q;

  assert_init_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> (load_o && update_o));
  assert_sync_now_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_now |=> update_o);
  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (bypass_o == $past(ctrl_wdata_i[0])));
endmodule

// File: tb/agc_sync_ctrl_test.sv
`timescale 1ns/1ps
module agc_sync_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [3:0]  ctrl_wdata = 4'd0;
  logic [15:0] holdoff = 16'd0;
  logic        pin_sync = 1'b0;
  logic        update_o, clear_o, load_o, bypass_o;
  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  agc_sync_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .holdoff_i(holdoff), .pin_sync_i(pin_sync),
    .update_o(update_o), .clear_o(clear_o), .load_o(load_o), .bypass_o(bypass_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [3:0] d);
    ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  // pin pulses after step pa / pb, a control write after step nw (0 = before first edge)
  task automatic watch(input int n, input int pa, input int pb, input int nw,
                       input logic [3:0] nd, output int first, output int cnt,
                       output int clr, output int ld);
    first = -1; cnt = 0; clr = 0; ld = 0;
    pin_sync = (pa == 0) || (pb == 0);
    if (nw == 0) begin ctrl_wr = 1'b1; ctrl_wdata = nd; end
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (update_o) begin
        cnt++;
        if (first < 0) begin first = i; clr = clear_o; ld = load_o; end
      end
      pin_sync = (i == pa) || (i == pb);
      ctrl_wr  = (i == nw);
      if (i == nw) ctrl_wdata = nd;
    end
    pin_sync = 1'b0; ctrl_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int f, c, cl, ld;
    repeat (3) @(negedge clk);
    chk("R12 reset update", update_o, 0);
    chk("R12 reset bypass", bypass_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 post-reset strobes", {update_o, clear_o, load_o}, 0);

    // R1 R6 R7: latency sweep over hold-off values and init setting
    for (int h = 1; h <= 12; h++) begin
      for (int in = 0; in < 2; in++) begin
        write_ctrl({1'b0, in[0], 2'b00});
        holdoff = 16'(h);
        watch(h + 12, 0, -1, -1, 4'd0, f, c, cl, ld);
        chk("R1 latency", f, h + 3);
        chk("R1 single pulse", c, 1);
        chk(in ? "R6 clear" : "R7 clear", cl, in);
        chk(in ? "R6 load" : "R7 load", ld, in);
      end
    end

    // R2 retrigger
    write_ctrl(4'b0000); holdoff = 16'd10;
    watch(40, 0, 4, -1, 4'd0, f, c, cl, ld);
    chk("R2 retrigger latency", f, 17);
    chk("R2 retrigger single", c, 1);

    // R3 zero hold-off
    holdoff = 16'd0;
    watch(30, 0, -1, -1, 4'd0, f, c, cl, ld);
    chk("R3 zero blocks", c, 0);
    holdoff = 16'd4;
    watch(20, -1, -1, -1, 4'd0, f, c, cl, ld);
    chk("R3 no count started", c, 0);

    // R4 sync-now cancels a running count
    holdoff = 16'd10;
    watch(30, 0, -1, 4, 4'b1000, f, c, cl, ld);
    chk("R4 sync-now latency", f, 5);
    chk("R4 count cancelled", c, 1);
    chk("R7 sync-now no clear", cl, 0);

    // R5 repeated sync-now writes, R6 init from write data
    watch(3, -1, -1, 0, 4'b1100, f, c, cl, ld);
    chk("R5 first sync-now", f, 1);
    chk("R6 init from write", cl, 1);
    watch(3, -1, -1, 0, 4'b1100, f, c, cl, ld);
    chk("R5 second sync-now", c, 1);
    chk("R6 load from write", ld, 1);

    // R11 collision on expiry cycle
    write_ctrl(4'b0000); holdoff = 16'd5;
    watch(20, 0, -1, 7, 4'b1000, f, c, cl, ld);
    chk("R11 collision edge", f, 8);
    chk("R11 collision single", c, 1);

    // R8 ignore-repeat, R9 rearm
    write_ctrl(4'b0010); holdoff = 16'd3;
    watch(15, 0, -1, -1, 4'd0, f, c, cl, ld);
    chk("R8 first accepted", c, 1);
    watch(15, 0, -1, -1, 4'd0, f, c, cl, ld);
    chk("R8 repeat ignored", c, 0);
    write_ctrl(4'b0000);
    write_ctrl(4'b0010);
    watch(15, 0, -1, -1, 4'd0, f, c, cl, ld);
    chk("R9 rearmed", c, 1);
    write_ctrl(4'b0000);

    // R10 bypass
    write_ctrl(4'b0001);
    chk("R10 bypass set", bypass_o, 1);
    write_ctrl(4'b0000);
    chk("R10 bypass clear", bypass_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule